// File: doc/BRIEF.md
# Register File Address Glitch Checker

This block sits next to a small flop-based register file and guards its address decoding against glitches and faults. It decodes the write address, qualified by the write strobe, into a one-hot write-enable vector that drives the storage flops. It also decodes each of the two read addresses into a one-hot select vector for the read multiplexers.

Every vector passes through a buffer stage before it reaches its checker. The buffer is a separate module boundary that is meant to be kept, so that synthesis cannot fold the checker back into the decoder it watches.

Each checker tests three things against the buffered vector: more than one bit set, the wrong bit compared with the binary address, and disagreement with the enable. Read addresses always count as valid. Each checker's verdict is held in a register, and the three registered flags are merged into one combined error. Two build-time switches remove the write-side checker and the read-side checkers independently. When a checker is removed, its flag is tied low. The decoded vectors are always produced.

Top module: `rfg_guard`

## Requirements
- R1: `we_onehot` bit i is 1 exactly when `wr_en` is 1 and `waddr` equals i; with `wr_en` at 0 every bit is 0.
- R2: `rsel_a_onehot` and `rsel_b_onehot` each have exactly one bit set, at the position given by `raddr_a` and `raddr_b` respectively, regardless of `wr_en`.
- R3: The three error flags are registers. They read 0 after a clock edge with `rst_n` low, and each takes the verdict of the inputs seen at the previous rising edge, clearing again one edge after a fault disappears.
- R4: A checked vector with two or more bits set raises that port's flag at the next rising edge.
- R5: A checked vector with a single bit set at a position other than the address, while its enable is 1, raises that port's flag at the next rising edge.
- R6: A checked vector with any bit set while its enable is 0, or with no bit set while its enable is 1, raises that port's flag at the next rising edge. The read enables are fixed at 1.
- R7: `err_any` is 1 exactly when at least one of `err_we`, `err_ra`, `err_rb` is 1. A fault on one port sets only that port's flag.
- R8: With `WE_CHECK` = 0, `err_we` stays 0 even for a faulty write vector, and `we_onehot` still follows R1.
- R9: With `RD_CHECK` = 0, `err_ra` and `err_rb` stay 0 even for faulty read vectors.
- R10: With fault-free decoding, every address and strobe combination leaves all flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| raddr_a | input | ADDR_W | Read address, port A |
| raddr_b | input | ADDR_W | Read address, port B |
| waddr | input | ADDR_W | Write address |
| wr_en | input | 1 | Write strobe |
| we_onehot | output | 2**ADDR_W | One-hot write enables for the storage flops |
| rsel_a_onehot | output | 2**ADDR_W | One-hot read select, port A |
| rsel_b_onehot | output | 2**ADDR_W | One-hot read select, port B |
| err_we | output | 1 | Registered write-decode error |
| err_ra | output | 1 | Registered read-select error, port A |
| err_rb | output | 1 | Registered read-select error, port B |
| err_any | output | 1 | OR of the three error flags |

## Verification
The assertions assume that the address and strobe inputs are settled and known at every rising edge once reset is released. The stimulus meets this by changing inputs only on falling edges and holding reset low until they are defined. Faults are created only by overriding the buffered vectors between the decoder and the checker. The decoder outputs at the ports always stay clean, so the decode assertions on those ports remain valid while the checker flags react.

// File: rtl/rfg_pkg.sv
// Shared sizing helpers for the register file address glitch checker.
// Assumes address widths small enough that 2**aw fits an int.
package rfg_pkg;
    // Number of register words addressed by an address of width aw.
    function automatic int unsigned num_words(input int unsigned aw);
        return 32'd1 << aw;
    endfunction
endpackage

// File: rtl/rfg_onehot_enc.sv
// Binary-to-one-hot decoder with an enable.
// Bit i of the result is set only when en is high and addr equals i.
// Assumes addr is a full binary index into 2**ADDR_W positions.
module rfg_onehot_enc #(
    parameter int unsigned ADDR_W = 5,
    localparam int unsigned NW = rfg_pkg::num_words(ADDR_W)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    output logic [NW-1:0]     oh
);
    // One comparator per position; repeated structure built by generate.
    for (genvar i = 0; i < NW; i++) begin : g_bit
        assign oh[i] = en && (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/rfg_keep_buf.sv
// Pass-through buffer that marks a boundary which must be kept intact.
// It separates a decoder from its checker, so that the checker cannot be
// merged into the logic it observes. It has no timing and no state.
module rfg_keep_buf #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // Straight wire copy across the kept boundary.
    assign dout = din;
endmodule

// File: rtl/rfg_onehot_chk.sv
// Registered checker for one decoded one-hot vector.
// It flags more than one bit set, a set bit that does not match the binary
// address, and disagreement between the vector and its enable.
// Assumes oh comes from a kept buffer and addr/en are the decoder's inputs.
module rfg_onehot_chk #(
    parameter int unsigned ADDR_W = 5,
    localparam int unsigned NW = rfg_pkg::num_words(ADDR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NW-1:0]     oh,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    output logic              err
);
    logic any_set;
    logic multi_set;
    logic addr_bad;
    logic en_bad;
    logic err_q;

    // Classify the vector against its address and enable.
    always_comb begin
        any_set   = |oh;
        multi_set = (oh & (oh - NW'(1))) != '0;
        addr_bad  = en && !oh[addr];
        en_bad    = any_set != en;
    end

    // Hold the verdict for one cycle; synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= multi_set || addr_bad || en_bad;
    end

    assign err = err_q;

    a_r4_multi_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(oh) > 1) |=> err);
    a_r5_wrong_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $onehot(oh) && !oh[addr]) |=> err);
    a_r6_set_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && (oh != '0)) |=> err);
    a_r6_none_when_on: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (oh == '0)) |=> err);
    a_r10_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $onehot(oh) && oh[addr]) |=> !err);
endmodule

// File: rtl/rfg_guard.sv
// Address decoding guard for a small register file.
// It decodes the write address into one-hot write enables and decodes two
// read addresses into one-hot selects. Each vector passes through a kept
// buffer to an optional registered checker, and the flags are merged.
// Assumes inputs are stable at each rising edge; reads are always valid.
module rfg_guard #(
    parameter int unsigned ADDR_W   = 5,
    parameter bit          WE_CHECK = 1'b1,
    parameter bit          RD_CHECK = 1'b1,
    localparam int unsigned NW = rfg_pkg::num_words(ADDR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic [ADDR_W-1:0] raddr_b,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wr_en,
    output logic [NW-1:0]     we_onehot,
    output logic [NW-1:0]     rsel_a_onehot,
    output logic [NW-1:0]     rsel_b_onehot,
    output logic              err_we,
    output logic              err_ra,
    output logic              err_rb,
    output logic              err_any
);
    logic [NW-1:0] we_buf;
    logic [NW-1:0] ra_buf;
    logic [NW-1:0] rb_buf;

    // Decoders: write qualified by the strobe, reads always enabled.
    rfg_onehot_enc #(.ADDR_W(ADDR_W)) u_enc_we (.addr(waddr),   .en(wr_en), .oh(we_onehot));
    rfg_onehot_enc #(.ADDR_W(ADDR_W)) u_enc_ra (.addr(raddr_a), .en(1'b1),  .oh(rsel_a_onehot));
    rfg_onehot_enc #(.ADDR_W(ADDR_W)) u_enc_rb (.addr(raddr_b), .en(1'b1),  .oh(rsel_b_onehot));

    // Kept boundaries between each decoder and its checker.
    rfg_keep_buf #(.W(NW)) u_buf_we (.din(we_onehot),     .dout(we_buf));
    rfg_keep_buf #(.W(NW)) u_buf_ra (.din(rsel_a_onehot), .dout(ra_buf));
    rfg_keep_buf #(.W(NW)) u_buf_rb (.din(rsel_b_onehot), .dout(rb_buf));

    // Write-side checker, present only when selected at build time.
    if (WE_CHECK) begin : g_we_chk
        rfg_onehot_chk #(.ADDR_W(ADDR_W)) u_chk_we (
            .clk(clk), .rst_n(rst_n), .oh(we_buf), .addr(waddr), .en(wr_en), .err(err_we));
    end else begin : g_we_off
        logic unused_we;
        assign unused_we = ^we_buf;
        assign err_we    = 1'b0;
    end

    // Read-side checkers, present only when selected at build time.
    if (RD_CHECK) begin : g_rd_chk
        rfg_onehot_chk #(.ADDR_W(ADDR_W)) u_chk_ra (
            .clk(clk), .rst_n(rst_n), .oh(ra_buf), .addr(raddr_a), .en(1'b1), .err(err_ra));
        rfg_onehot_chk #(.ADDR_W(ADDR_W)) u_chk_rb (
            .clk(clk), .rst_n(rst_n), .oh(rb_buf), .addr(raddr_b), .en(1'b1), .err(err_rb));
    end else begin : g_rd_off
        logic unused_rd;
        assign unused_rd = ^{ra_buf, rb_buf};
        assign err_ra    = 1'b0;
        assign err_rb    = 1'b0;
    end

    // Combined flag for the surrounding fault handler.
    assign err_any = err_we || err_ra || err_rb;

    a_r1_we_hit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (we_onehot[waddr] && $onehot(we_onehot)));
    a_r1_we_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (we_onehot == '0));
    a_r2_rsel_a: assert property (@(posedge clk) disable iff (!rst_n)
        rsel_a_onehot[raddr_a] && $onehot(rsel_a_onehot));
    a_r2_rsel_b: assert property (@(posedge clk) disable iff (!rst_n)
        rsel_b_onehot[raddr_b] && $onehot(rsel_b_onehot));
    a_r3_reset_clear: assert property (@(posedge clk)
        !rst_n |=> !err_any);
endmodule

// File: tb/tb_rfg_guard.sv
module tb_rfg_guard;
    localparam int unsigned AW = 5;
    localparam int unsigned NW = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] raddr_a = '0, raddr_b = '0, waddr = '0;
    logic wr_en = 1'b0;
    logic [NW-1:0] we_oh, ra_oh, rb_oh, we_oh2, ra_oh2, rb_oh2;
    logic e_we, e_ra, e_rb, e_any, e_we2, e_ra2, e_rb2, e_any2;
    logic [NW-1:0] fv_we, fv_ra, fv_rb;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    rfg_guard #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .raddr_a(raddr_a), .raddr_b(raddr_b),
        .waddr(waddr), .wr_en(wr_en), .we_onehot(we_oh), .rsel_a_onehot(ra_oh),
        .rsel_b_onehot(rb_oh), .err_we(e_we), .err_ra(e_ra), .err_rb(e_rb), .err_any(e_any));

    rfg_guard #(.ADDR_W(AW), .WE_CHECK(1'b0), .RD_CHECK(1'b0)) dut_nochk (
        .clk(clk), .rst_n(rst_n), .raddr_a(raddr_a), .raddr_b(raddr_b),
        .waddr(waddr), .wr_en(wr_en), .we_onehot(we_oh2), .rsel_a_onehot(ra_oh2),
        .rsel_b_onehot(rb_oh2), .err_we(e_we2), .err_ra(e_ra2), .err_rb(e_rb2), .err_any(e_any2));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NW-1:0] bit_at(input int unsigned k);
        return NW'(1) << (k % NW);
    endfunction

    // One clock: edge, then settle on the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(); step();
        // R3: flags clear under reset
        chk("R3 reset flags", {e_we, e_ra, e_rb, e_any}, 4'b0);
        rst_n = 1'b1;

        // R1, R8, R10: sweep write address and strobe
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < NW; a++) begin
                waddr = AW'(a);
                wr_en = s[0];
                #1;
                chk("R1 we_onehot", we_oh, s ? bit_at(a) : '0);
                chk("R8 we_onehot unchecked", we_oh2, s ? bit_at(a) : '0);
                step();
                chk("R10 clean write", e_any, 1'b0);
            end
        end
        wr_en = 1'b0;

        // R2, R10: sweep both read addresses
        for (int a = 0; a < NW; a++) begin
            for (int b = 0; b < NW; b++) begin
                raddr_a = AW'(a);
                raddr_b = AW'(b);
                wr_en = (a + b) % 2 == 1;
                #1;
                chk("R2 rsel_a", ra_oh, bit_at(a));
                chk("R2 rsel_b", rb_oh, bit_at(b));
                step();
                chk("R10 clean read", {e_we, e_ra, e_rb, e_any}, 4'b0);
            end
        end

        // Fault injection on write vector
        for (int k = 0; k < NW; k += 7) begin
            waddr = AW'(k); wr_en = 1'b1;
            fv_we = bit_at(k) | bit_at(k + 1);
            force dut.we_buf = fv_we;
            step();
            chk("R4 multi-bit write", e_we, 1'b1);
            chk("R7 any from write", {e_any, e_ra, e_rb}, 3'b100);
            fv_we = bit_at(k + 3);
            step();
            chk("R5 wrong bit write", e_we, 1'b1);
            fv_we = '0;
            step();
            chk("R6 none while enabled", e_we, 1'b1);
            wr_en = 1'b0; fv_we = bit_at(k);
            step();
            chk("R6 set while disabled", e_we, 1'b1);
            release dut.we_buf;
            step();
            chk("R3 clears after fault", e_any, 1'b0);
        end

        // Fault injection on read vectors
        for (int k = 1; k < NW; k += 9) begin
            raddr_a = AW'(k); raddr_b = AW'(k + 2);
            fv_ra = bit_at(k) | bit_at(k + 5) | bit_at(k + 6);
            force dut.ra_buf = fv_ra;
            step();
            chk("R4 multi-bit read a", {e_we, e_ra, e_rb, e_any}, 4'b0101);
            release dut.ra_buf;
            fv_rb = bit_at(k);
            force dut.rb_buf = fv_rb;
            step();
            chk("R5 wrong bit read b", {e_we, e_ra, e_rb, e_any}, 4'b0011);
            fv_rb = '0;
            step();
            chk("R6 empty read b", e_rb, 1'b1);
            release dut.rb_buf;
            step();
            chk("R3 read clears", e_any, 1'b0);
        end

        // R8, R9: faults into the unchecked build leave flags low
        waddr = 3; wr_en = 1'b1;
        fv_we = bit_at(4) | bit_at(9);
        fv_ra = '0;
        fv_rb = bit_at(20);
        force dut_nochk.we_buf = fv_we;
        force dut_nochk.ra_buf = fv_ra;
        force dut_nochk.rb_buf = fv_rb;
        step();
        chk("R8 write check off", e_we2, 1'b0);
        chk("R9 read checks off", {e_ra2, e_rb2, e_any2}, 3'b0);
        chk("R8 decode still driven", we_oh2, bit_at(3));
        release dut_nochk.we_buf;
        release dut_nochk.ra_buf;
        release dut_nochk.rb_buf;

        // R3: reset mid-fault clears the flag
        force dut.we_buf = bit_at(1) | bit_at(2);
        step();
        chk("R3 fault before reset", e_we, 1'b1);
        rst_n = 1'b0;
        step();
        chk("R3 reset clears flag", e_any, 1'b0);
        release dut.we_buf;
        rst_n = 1'b1;
        step();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule